// File: doc/BRIEF.md
# NaN Propagation Selector (single precision)

This unit decides which NaN a two-input single-precision arithmetic operation returns when at least one of its operands is a NaN. It sorts each operand into three kinds: quiet NaN, signaling NaN, or not a NaN. It then applies one of several priority policies and returns the chosen operand. A signaling NaN is made quiet before it is returned. The unit also raises an invalid-operation flag whenever a signaling NaN is present.

A surrounding floating-point datapath pulses `in_valid` with both operands, a policy code and a default-NaN-mode bit. One cycle later the unit presents the registered result and flag, with `out_valid` high. Producing the arithmetic result for operands that are not NaNs belongs to the surrounding datapath.

Top module: `nan_prop_sel`

## Requirements
- R1: Operand kinds follow from the 32-bit word. It is a NaN only when bits 30:23 are all ones. It is quiet when bit 22 is 1, and signaling when bit 22 is 0 and bits 21:0 are not all zero. Every other word, including infinity 0x7F800000, is not a NaN.
- R2: With policy code 0, the first match is taken in this order: a if a is signaling, then b if b is signaling, then a if a is quiet, and otherwise b.
- R3: Policy code 3 behaves exactly like policy code 0.
- R4: With policy code 1, a is returned if a is a NaN of either kind, and otherwise b.
- R5: With policy code 2, one NaN of each kind yields the quiet one. A single NaN paired with a non-NaN yields that NaN.
- R6: With policy code 2, two NaNs of the same kind yield the one with the larger significand. Operand a counts as larger when (a<<1) is greater than (b<<1) as unsigned values. When those are equal, a counts as larger when a < b as an unsigned 32-bit word, which favours the positive sign.
- R7: A selected signaling NaN is returned with bit 22 set and all other bits unchanged. A selected quiet NaN is returned unchanged.
- R8: `invalid` is 1 exactly when a or b is a signaling NaN. This holds in default-NaN mode as well.
- R9: When `dflt_mode` is 1, `result` is 0xFFC00000 whatever the policy code.
- R10: `result` and `invalid` are captured on a clock edge at which `in_valid` is 1, and `out_valid` is high in the cycle that follows. Without a strobe, `out_valid` is 0 and `result` and `invalid` hold their values. Reset clears all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| policy | input | 2 | 0 ordered, 1 a-first, 2 magnitude, 3 same as 0 |
| dflt_mode | input | 1 | Return the default NaN instead of an operand |
| out_valid | output | 1 | Result and flag are updated |
| result | output | 32 | Selected and quieted NaN |
| invalid | output | 1 | A signaling NaN was seen |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing and output hold;
- the default NaN in default-NaN mode;
- the invalid flag whenever a signaling operand appears;
- an output that is always quiet when any operand is a NaN;
- that a single NaN beside a non-NaN always wins, quieted, under every policy.

The per-policy orderings, the reserved code 3, the significand tie-break with its sign fallback, and the classification edges such as infinity and a bare quiet bit can only be shown by the bench's directed scenarios. Those scenarios compare against expected words worked out from the requirements.

// File: rtl/nanx_pkg.sv
package nanx_pkg;
  typedef enum logic [1:0] {
    POL_ORDERED   = 2'd0,
    POL_A_FIRST   = 2'd1,
    POL_MAGNITUDE = 2'd2,
    POL_RESERVED  = 2'd3
  } policy_e;

  typedef struct packed {
    logic quiet;
    logic signaling;
  } nan_kind_t;
endpackage

// File: rtl/nanx_classify.sv
module nanx_classify
  import nanx_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic [EXP_W+FRAC_W:0] word,
  output nan_kind_t              kind
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic exp_ones;
  logic qbit;
  logic low_any;

  always_comb begin
    exp_ones       = &word[W-2:FRAC_W];
    qbit           = word[FRAC_W-1];
    low_any        = |word[FRAC_W-2:0];
    kind.quiet     = exp_ones & qbit;
    kind.signaling = exp_ones & ~qbit & low_any;
  end
endmodule

// File: rtl/nanx_pick.sv
module nanx_pick
  import nanx_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  nan_kind_t    ka,
  input  nan_kind_t    kb,
  input  logic [1:0]   policy,
  output logic         take_b
);
  logic [W-1:0] mag_a;
  logic [W-1:0] mag_b;
  logic         a_larger;
  logic         a_nan;
  logic         b_nan;

  always_comb begin
    mag_a    = {a[W-2:0], 1'b0};
    mag_b    = {b[W-2:0], 1'b0};
    a_larger = (mag_a > mag_b) || ((mag_a == mag_b) && (a < b));
    a_nan    = ka.quiet | ka.signaling;
    b_nan    = kb.quiet | kb.signaling;
    take_b   = 1'b1;
    unique case (policy_e'(policy))
      POL_A_FIRST: take_b = ~a_nan;
      POL_MAGNITUDE: begin
        if (ka.signaling) begin
          if (kb.signaling) take_b = ~a_larger;
          else              take_b = kb.quiet;
        end else if (ka.quiet) begin
          if (kb.signaling || !b_nan) take_b = 1'b0;
          else                        take_b = ~a_larger;
        end else begin
          take_b = 1'b1;
        end
      end
      default: begin
        if (ka.signaling)      take_b = 1'b0;
        else if (kb.signaling) take_b = 1'b1;
        else if (ka.quiet)     take_b = 1'b0;
        else                   take_b = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/nanx_shape.sv
module nanx_shape #(
  parameter int          W        = 32,
  parameter int          QBIT     = 22,
  parameter logic [31:0] DFLT_NAN = 32'hFFC0_0000
) (
  input  logic [W-1:0] chosen,
  input  logic         chosen_sig,
  input  logic         dflt_mode,
  output logic [W-1:0] shaped
);
  localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

  always_comb begin
    if (dflt_mode)       shaped = DFLT_NAN[W-1:0];
    else if (chosen_sig) shaped = chosen | QMASK;
    else                 shaped = chosen;
  end
endmodule

// File: rtl/nan_prop_sel.sv
module nan_prop_sel
  import nanx_pkg::*;
#(
  parameter int          EXP_W    = 8,
  parameter int          FRAC_W   = 23,
  parameter logic [31:0] DFLT_NAN = 32'hFFC0_0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  input  logic [EXP_W+FRAC_W:0]  op_a,
  input  logic [EXP_W+FRAC_W:0]  op_b,
  input  logic [1:0]             policy,
  input  logic                   dflt_mode,
  output logic                   out_valid,
  output logic [EXP_W+FRAC_W:0]  result,
  output logic                   invalid
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;
  localparam int NOPS = 2;
  localparam logic [W-1:0] QMASK = {{(W-1){1'b0}}, 1'b1} << QBIT;

  logic [W-1:0] ops [NOPS];
  nan_kind_t    kinds [NOPS];
  logic [NOPS-1:0] is_nan;
  logic [NOPS-1:0] is_sig;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    nanx_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .word (ops[i]),
      .kind (kinds[i])
    );
    assign is_nan[i] = kinds[i].quiet | kinds[i].signaling;
    assign is_sig[i] = kinds[i].signaling;
  end

  logic         take_b;
  logic [W-1:0] chosen;
  logic         chosen_sig;
  logic [W-1:0] shaped;

  nanx_pick #(.W(W)) u_pick (
    .a      (op_a),
    .b      (op_b),
    .ka     (kinds[0]),
    .kb     (kinds[1]),
    .policy (policy),
    .take_b (take_b)
  );

  assign chosen     = take_b ? op_b : op_a;
  assign chosen_sig = take_b ? is_sig[1] : is_sig[0];

  nanx_shape #(.W(W), .QBIT(QBIT), .DFLT_NAN(DFLT_NAN)) u_shape (
    .chosen     (chosen),
    .chosen_sig (chosen_sig),
    .dflt_mode  (dflt_mode),
    .shaped     (shaped)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      invalid   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= shaped;
        invalid <= |is_sig;
      end
    end
  end

  // R10 timing of the valid output and holding of the data outputs
  a_r10_valid_follow: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r10_valid_drop: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(result) && $stable(invalid)));
  // R9 default NaN
  a_r9_default: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dflt_mode) |=> (result == DFLT_NAN[W-1:0]));
  // R8 flag raised for any signaling operand
  a_r8_flag: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (is_sig != '0)) |=> invalid);
  // R7 output is a quiet NaN whenever an operand is a NaN
  a_r7_quiet_out: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (is_nan != '0)) |=> (result[QBIT] && (&result[W-2:FRAC_W])));
  // R5 a lone NaN wins under every policy
  a_r5_lone_a: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dflt_mode && is_nan[0] && !is_nan[1]) |=> (result == ($past(op_a) | QMASK)));
  a_r5_lone_b: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !dflt_mode && !is_nan[0] && is_nan[1]) |=> (result == ($past(op_b) | QMASK)));
endmodule

// File: tb/nan_prop_sel_test.sv
`timescale 1ns/1ps
module nan_prop_sel_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [1:0]  policy = '0;
  logic        dflt_mode = 1'b0;
  logic        out_valid;
  logic [31:0] result;
  logic        invalid;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  nan_prop_sel uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .policy(policy), .dflt_mode(dflt_mode), .out_valid(out_valid),
    .result(result), .invalid(invalid)
  );

  localparam logic [31:0] QA  = 32'h7FC0_0001;
  localparam logic [31:0] QB  = 32'hFFC0_0002;
  localparam logic [31:0] SA  = 32'h7F80_0001;
  localparam logic [31:0] SB  = 32'h7FA0_0000;
  localparam logic [31:0] ONE = 32'h3F80_0000;
  localparam logic [31:0] INF = 32'h7F80_0000;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one strobe and check the registered outputs one cycle later.
  task automatic apply(input string tag, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] pol, input logic dn,
                       input logic [31:0] exp_res, input logic exp_inv);
    @(negedge clk);
    op_a = a; op_b = b; policy = pol; dflt_mode = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " out_valid"}, {31'd0, out_valid}, 32'd1);
    check({tag, " result"}, result, exp_res);
    check({tag, " invalid"}, {31'd0, invalid}, {31'd0, exp_inv});
  endtask

  task automatic t_reset;
    // R10 reset values
    check("R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 reset result", result, 32'd0);
    check("R10 reset invalid", {31'd0, invalid}, 32'd0);
  endtask

  task automatic t_classify;
    // R1: infinity is not a NaN, bare quiet bit is quiet, low bit alone is signaling
    apply("R1 inf vs quiet", INF, QB, 2'd0, 1'b0, QB, 1'b0);
    apply("R1 bare quiet", 32'h7FC0_0000, ONE, 2'd0, 1'b0, 32'h7FC0_0000, 1'b0);
    apply("R1 low signaling", SA, ONE, 2'd0, 1'b0, 32'h7FC0_0001, 1'b1);
  endtask

  task automatic t_pol0;
    // R2 ordered priority
    apply("R2 b signaling beats a quiet", QA, SB, 2'd0, 1'b0, 32'h7FE0_0000, 1'b1);
    apply("R2 a signaling first", SA, SB, 2'd0, 1'b0, 32'h7FC0_0001, 1'b1);
    apply("R2 a quiet over b quiet", QA, QB, 2'd0, 1'b0, QA, 1'b0);
  endtask

  task automatic t_pol3;
    // R3 reserved code matches code 0
    apply("R3 b signaling", QA, SB, 2'd3, 1'b0, 32'h7FE0_0000, 1'b1);
    apply("R3 quiet pair", QA, QB, 2'd3, 1'b0, QA, 1'b0);
  endtask

  task automatic t_pol1;
    // R4 a first regardless of kind
    apply("R4 a quiet vs b signaling", QA, SB, 2'd1, 1'b0, QA, 1'b1);
    apply("R4 a not nan", ONE, SB, 2'd1, 1'b0, 32'h7FE0_0000, 1'b1);
  endtask

  task automatic t_pol2_mixed;
    // R5 quiet wins over signaling; lone NaN wins
    apply("R5 signaling a quiet b", SA, QB, 2'd2, 1'b0, QB, 1'b1);
    apply("R5 quiet a signaling b", QA, SB, 2'd2, 1'b0, QA, 1'b1);
    apply("R5 lone b", ONE, QB, 2'd2, 1'b0, QB, 1'b0);
  endtask

  task automatic t_pol2_same;
    // R6 larger significand, tie resolved to the positive sign
    apply("R6 two signaling", 32'h7F80_0010, 32'h7F80_0020, 2'd2, 1'b0, 32'h7FC0_0020, 1'b1);
    apply("R6 two quiet a larger", 32'h7FC0_0009, 32'h7FC0_0003, 2'd2, 1'b0, 32'h7FC0_0009, 1'b0);
    apply("R6 tie a positive", 32'h7FC0_0005, 32'hFFC0_0005, 2'd2, 1'b0, 32'h7FC0_0005, 1'b0);
    apply("R6 tie b positive", 32'hFFC0_0005, 32'h7FC0_0005, 2'd2, 1'b0, 32'h7FC0_0005, 1'b0);
  endtask

  task automatic t_quiet;
    // R7 quiet passes untouched, signaling gets bit 22 only
    apply("R7 signaling negative", 32'hFF80_1234, ONE, 2'd0, 1'b0, 32'hFFC0_1234, 1'b1);
    apply("R7 quiet unchanged", 32'hFFE0_0007, ONE, 2'd1, 1'b0, 32'hFFE0_0007, 1'b0);
  endtask

  task automatic t_dn;
    // R9 default NaN; R8 flag still raised
    apply("R9 default quiet", QA, QB, 2'd1, 1'b1, 32'hFFC0_0000, 1'b0);
    apply("R8 flag in default mode", SA, ONE, 2'd2, 1'b1, 32'hFFC0_0000, 1'b1);
  endtask

  task automatic t_hold;
    // R10 outputs hold without a strobe
    apply("R10 load", SA, QB, 2'd0, 1'b0, 32'h7FC0_0001, 1'b1);
    @(negedge clk);
    op_a = QA; op_b = QB; policy = 2'd1; dflt_mode = 1'b1;
    @(negedge clk);
    check("R10 hold out_valid", {31'd0, out_valid}, 32'd0);
    check("R10 hold result", result, 32'h7FC0_0001);
    check("R10 hold invalid", {31'd0, invalid}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    @(negedge clk);
    rst = 1'b0;
    t_classify();
    t_pol0();
    t_pol3();
    t_pol1();
    t_pol2_mixed();
    t_pol2_same();
    t_quiet();
    t_dn();
    t_hold();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule